// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Flags

This block is a two-port word memory, 4096 entries of 16 bits by default, in which each side owns its own chip select, write strobe, output enable, per-byte lane selects, address, write data and read data. Both sides run on one clock and may touch any entry in the same cycle, including the same entry. Reads are registered and return one clock after the request.

The two highest entries serve two purposes. They are ordinary storage, and they are doorbells between the sides. A write by the right side into the second-highest entry raises the left side's flag. A write by the left side into the highest entry raises the right side's flag. Each side lowers its own flag by reading its own mailbox entry. Each side also has a write-inhibit input, normally driven by an external collision arbiter. An inhibited write leaves memory untouched and rings no doorbell.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: Every entry written by either side with both lane selects high (be = 2'b11) reads back, from either side, as the value last written.
- R2: Lane select bit 1 governs bits 15..8 and bit 0 governs bits 7..0. A write changes only the selected lanes. A read returns the selected lanes and zero in the unselected lanes. With be = 2'b00, a write changes nothing and a read returns 0.
- R3: A read happens when cs = 1, oe = 1 and wr = 0. Its data appears on the read port after the next rising edge. In any cycle without a read, the read port keeps its previous value.
- R4: When one side writes an entry and the other side reads the same entry in the same cycle, the read returns the value held before the write.
- R5: When both sides write the same lane of the same entry in the same cycle, the left side's data is stored.
- R6: A non-inhibited write (cs = 1, wr = 1) by the right side to address DEPTH-2 (0xFFE) sets l_irq. A non-inhibited write by the left side to DEPTH-1 (0xFFF) sets r_irq. Both hold whatever the lane selects are.
- R7: An access by the left side with cs = 1 and oe = 1 to 0xFFE clears l_irq, whatever the value of wr. The right side clears r_irq the same way at 0xFFF.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: While a side's winh is 1, a write from that side changes no memory lane and sets no flag on the other side.
- R10: The mailbox entries store and return written data like any other entry.
- R11: Both flags are active-high and registered, and change on the rising edge that ends the causing cycle. While rst_n is low, both flags and both read ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left chip select |
| l_wr | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_be | input | 2 | Left lane selects (bit 1 upper, bit 0 lower) |
| l_addr | input | 12 | Left address |
| l_wdata | input | 16 | Left write data |
| l_winh | input | 1 | Left write inhibit |
| l_rdata | output | 16 | Left registered read data |
| l_irq | output | 1 | Left mailbox flag |
| r_cs | input | 1 | Right chip select |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_be | input | 2 | Right lane selects (bit 1 upper, bit 0 lower) |
| r_addr | input | 12 | Right address |
| r_wdata | input | 16 | Right write data |
| r_winh | input | 1 | Right write inhibit |
| r_rdata | output | 16 | Right registered read data |
| r_irq | output | 1 | Right mailbox flag |

## Verification
Each result is due exactly one rising edge after its cause. Read data, flag sets and flag clears all appear after the edge that samples the request. A written value is visible to a read issued in the following cycle or later, never to a read in the same cycle. The bench drives stimulus on the falling edge. Its reference model updates on the rising edge from the inputs held stable across that edge, and it compares both read ports and both flags at the next falling edge. This places every comparison in the cycle where the result is due, with no process racing the edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // Classification of one side's request in a cycle
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_BLOCK = 2'd3
   } acc_e;

endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
   import dpr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LANES     = 2,
   parameter int OWN_MBOX  = 4094,
   parameter int PEER_MBOX = 4095
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic              oe,
   input  logic [LANES-1:0]  be,
   input  logic [ADDR_W-1:0] addr,
   input  logic              winh,
   output logic [LANES-1:0]  wr_lanes,
   output logic              rd_en,
   output logic              peer_set,
   output logic              own_clr
);

   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MBOX);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MBOX);

   acc_e acc;

   always_comb begin
      if (cs && wr)
         acc = winh ? ACC_BLOCK : ACC_WRITE;
      else if (cs && oe)
         acc = ACC_READ;
      else
         acc = ACC_IDLE;
   end

   assign wr_lanes = (acc == ACC_WRITE) ? be : '0;
   assign rd_en    = (acc == ACC_READ);
   assign peer_set = (acc == ACC_WRITE) && (addr == PEER_A);
   // clearing ignores the write strobe and the inhibit
   assign own_clr  = cs && oe && (addr == OWN_A);

   // R9: an inhibited side drives no lane write and rings no doorbell
   p_inhibit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      winh |-> (wr_lanes == '0 && !peer_set));

   // R3: a read and a lane write never come from one side together
   p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && (wr_lanes != '0)));

endmodule

// File: rtl/dpr_lane_mem.sv
module dpr_lane_mem #(
   parameter int ADDR_W = 12,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic              a_rd,
   input  logic              a_sel,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [LANE_W-1:0] a_din,
   output logic [LANE_W-1:0] a_dout,
   input  logic              b_we,
   input  logic              b_rd,
   input  logic              b_sel,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [LANE_W-1:0] b_din,
   output logic [LANE_W-1:0] b_dout
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] store [DEPTH];

   // side a is written last, so it wins a same-entry collision (R5)
   always_ff @(posedge clk) begin
      if (b_we) store[b_addr] <= b_din;
      if (a_we) store[a_addr] <= a_din;
   end

   // reads sample the array before this edge's writes land (R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_dout <= '0;
         b_dout <= '0;
      end else begin
         if (a_rd) a_dout <= a_sel ? store[a_addr] : '0;
         if (b_rd) b_dout <= b_sel ? store[b_addr] : '0;
      end
   end

   // R3: read data holds when no read is issued
   p_a_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !a_rd |=> $stable(a_dout));
   p_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !b_rd |=> $stable(b_dout));

endmodule

// File: rtl/dpr_mbox_flag.sv
module dpr_mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (set)
         irq <= 1'b1;
      else if (clr)
         irq <= 1'b0;
   end

   // R8: a set always leaves the flag high, even against a clear
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> irq);
   // R7: a clear alone drops the flag
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !irq);
   // R6: with neither event the flag holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set) |=> $stable(irq));

endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  l_cs,
   input  logic                  l_wr,
   input  logic                  l_oe,
   input  logic [DATA_W/8-1:0]   l_be,
   input  logic [ADDR_W-1:0]     l_addr,
   input  logic [DATA_W-1:0]     l_wdata,
   input  logic                  l_winh,
   output logic [DATA_W-1:0]     l_rdata,
   output logic                  l_irq,
   input  logic                  r_cs,
   input  logic                  r_wr,
   input  logic                  r_oe,
   input  logic [DATA_W/8-1:0]   r_be,
   input  logic [ADDR_W-1:0]     r_addr,
   input  logic [DATA_W-1:0]     r_wdata,
   input  logic                  r_winh,
   output logic [DATA_W-1:0]     r_rdata,
   output logic                  r_irq
);

   localparam int LANE_W = 8;
   localparam int LANES  = DATA_W / LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int L_MBOX = DEPTH - 2;
   localparam int R_MBOX = DEPTH - 1;

   generate
      if (DATA_W < LANE_W || (DATA_W % LANE_W) != 0) begin : g_bad_width
         $error("DATA_W must be a positive multiple of the lane width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must leave room for two mailbox entries");
      end
   endgenerate

   logic [LANES-1:0] l_wl, r_wl;
   logic             l_rd, r_rd;
   logic             l_set_peer, r_set_peer;
   logic             l_clr_own, r_clr_own;

   dpr_port_ctl #(
      .ADDR_W(ADDR_W), .LANES(LANES), .OWN_MBOX(L_MBOX), .PEER_MBOX(R_MBOX)
   ) i_lctl (
      .clk(clk), .rst_n(rst_n),
      .cs(l_cs), .wr(l_wr), .oe(l_oe), .be(l_be), .addr(l_addr), .winh(l_winh),
      .wr_lanes(l_wl), .rd_en(l_rd), .peer_set(l_set_peer), .own_clr(l_clr_own)
   );

   dpr_port_ctl #(
      .ADDR_W(ADDR_W), .LANES(LANES), .OWN_MBOX(R_MBOX), .PEER_MBOX(L_MBOX)
   ) i_rctl (
      .clk(clk), .rst_n(rst_n),
      .cs(r_cs), .wr(r_wr), .oe(r_oe), .be(r_be), .addr(r_addr), .winh(r_winh),
      .wr_lanes(r_wl), .rd_en(r_rd), .peer_set(r_set_peer), .own_clr(r_clr_own)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dpr_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_lane (
            .clk(clk), .rst_n(rst_n),
            .a_we(l_wl[g]), .a_rd(l_rd), .a_sel(l_be[g]), .a_addr(l_addr),
            .a_din(l_wdata[g*LANE_W +: LANE_W]),
            .a_dout(l_rdata[g*LANE_W +: LANE_W]),
            .b_we(r_wl[g]), .b_rd(r_rd), .b_sel(r_be[g]), .b_addr(r_addr),
            .b_din(r_wdata[g*LANE_W +: LANE_W]),
            .b_dout(r_rdata[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   // left flag: rung by the right side, cleared by the left side
   dpr_mbox_flag i_lflag (
      .clk(clk), .rst_n(rst_n), .set(r_set_peer), .clr(l_clr_own), .irq(l_irq)
   );

   // right flag: rung by the left side, cleared by the right side
   dpr_mbox_flag i_rflag (
      .clk(clk), .rst_n(rst_n), .set(l_set_peer), .clr(r_clr_own), .irq(r_irq)
   );

endmodule

// File: tb/test_dpr_mailbox_ram.sv
module test_dpr_mailbox_ram;

   localparam int AW = 12;
   localparam int DW = 16;
   localparam int DEPTH = 1 << AW;
   localparam logic [AW-1:0] LBOX = 12'hFFE;
   localparam logic [AW-1:0] RBOX = 12'hFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          l_cs = 0, l_wr = 0, l_oe = 0, l_winh = 0;
   logic [1:0]    l_be = 0;
   logic [AW-1:0] l_addr = 0;
   logic [DW-1:0] l_wdata = 0;
   logic          r_cs = 0, r_wr = 0, r_oe = 0, r_winh = 0;
   logic [1:0]    r_be = 0;
   logic [AW-1:0] r_addr = 0;
   logic [DW-1:0] r_wdata = 0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_irq, r_irq;

   dpr_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_mailbox_ram (
      .clk(clk), .rst_n(rst_n),
      .l_cs(l_cs), .l_wr(l_wr), .l_oe(l_oe), .l_be(l_be), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_winh(l_winh), .l_rdata(l_rdata), .l_irq(l_irq),
      .r_cs(r_cs), .r_wr(r_wr), .r_oe(r_oe), .r_be(r_be), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_winh(r_winh), .r_rdata(r_rdata), .r_irq(r_irq)
   );

   // ---------------- behavioural reference ----------------
   logic [DW-1:0] m_mem [DEPTH];
   logic [DW-1:0] m_lrd = 0, m_rrd = 0;
   logic          m_lirq = 0, m_rirq = 0;

   function automatic logic [DW-1:0] lanes(input logic [DW-1:0] v, input logic [1:0] be);
      return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [1:0] be);
      return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lrd = 0; m_rrd = 0; m_lirq = 0; m_rirq = 0;
      end else begin
         bit lw, rw, lset, rset, lclr, rclr;
         lw = l_cs && l_wr && !l_winh;
         rw = r_cs && r_wr && !r_winh;
         if (l_cs && l_oe && !l_wr) m_lrd = lanes(m_mem[l_addr], l_be);
         if (r_cs && r_oe && !r_wr) m_rrd = lanes(m_mem[r_addr], r_be);
         if (rw) m_mem[r_addr] = merge(m_mem[r_addr], r_wdata, r_be);
         if (lw) m_mem[l_addr] = merge(m_mem[l_addr], l_wdata, l_be);
         lset = rw && (r_addr == LBOX);
         rset = lw && (l_addr == RBOX);
         lclr = l_cs && l_oe && (l_addr == LBOX);
         rclr = r_cs && r_oe && (r_addr == RBOX);
         if (lset) m_lirq = 1; else if (lclr) m_lirq = 0;
         if (rset) m_rirq = 1; else if (rclr) m_rirq = 0;
      end
   end

   // ---------------- checking ----------------
   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   task automatic cmp(input string req, input string sig, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, sig, act, exp, $time);
      end
   endtask

   task automatic step(input string req);
      @(posedge clk);
      @(negedge clk);
      vectors++;
      cmp(req, "l_rdata", l_rdata, m_lrd);
      cmp(req, "r_rdata", r_rdata, m_rrd);
      cmp(req, "l_irq", {15'd0, l_irq}, {15'd0, m_lirq});
      cmp(req, "r_irq", {15'd0, r_irq}, {15'd0, m_rirq});
   endtask

   task automatic lset(input logic cs, wr, oe, input logic [1:0] be, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic inh);
      l_cs = cs; l_wr = wr; l_oe = oe; l_be = be; l_addr = a; l_wdata = d; l_winh = inh;
   endtask

   task automatic rset(input logic cs, wr, oe, input logic [1:0] be, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic inh);
      r_cs = cs; r_wr = wr; r_oe = oe; r_be = be; r_addr = a; r_wdata = d; r_winh = inh;
   endtask

   task automatic idle();
      lset(0, 0, 0, 2'b00, 0, 0, 0);
      rset(0, 0, 0, 2'b00, 0, 0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         miscompares++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      @(negedge clk);
      // R11: reset state
      step("R11"); step("R11");
      rst_n = 1'b1;
      step("R11");

      // R1: fill whole memory, left the low half, right the high half
      for (int i = 0; i < DEPTH / 2; i++) begin
         lset(1, 1, 0, 2'b11, AW'(i), DW'(i * 16'h9E37) ^ 16'h5A5A, 0);
         rset(1, 1, 0, 2'b11, AW'(i + DEPTH / 2), DW'(i * 16'h3C6B) ^ 16'hA5C3, 0);
         step("R1");
      end
      // R1: scattered reads from both sides
      for (int k = 0; k < 64; k++) begin
         lset(1, 0, 1, 2'b11, AW'((k * 37 + 11) % DEPTH), 0, 0);
         rset(1, 0, 1, 2'b11, AW'((k * 1291 + 5) % DEPTH), 0, 0);
         step("R1");
      end

      // R2: lane writes and lane reads
      idle();
      lset(1, 1, 0, 2'b01, 12'd100, 16'hAAAA, 0); step("R2");
      lset(1, 1, 0, 2'b10, 12'd101, 16'hBBBB, 0); step("R2");
      lset(1, 1, 0, 2'b00, 12'd102, 16'hCCCC, 0); step("R2");
      for (int a = 100; a < 103; a++) begin
         lset(1, 0, 1, 2'b11, AW'(a), 0, 0); rset(1, 0, 1, 2'b11, AW'(a), 0, 0); step("R2");
      end
      lset(1, 0, 1, 2'b10, 12'd100, 0, 0); rset(1, 0, 1, 2'b01, 12'd101, 0, 0); step("R2");
      lset(1, 0, 1, 2'b00, 12'd100, 0, 0); rset(1, 0, 1, 2'b00, 12'd101, 0, 0); step("R2");

      // R3: data holds without a read access
      lset(1, 0, 1, 2'b11, 12'd5, 0, 0); rset(1, 0, 1, 2'b11, 12'd6, 0, 0); step("R3");
      idle(); step("R3"); step("R3");
      lset(1, 0, 0, 2'b11, 12'd7, 0, 0); rset(0, 0, 1, 2'b11, 12'd8, 0, 0); step("R3");
      lset(1, 1, 1, 2'b11, 12'd9, 16'h7777, 0); rset(1, 1, 1, 2'b11, 12'd10, 16'h8888, 0);
      step("R3");
      idle();
      lset(1, 0, 1, 2'b11, 12'd9, 0, 0); rset(1, 0, 1, 2'b11, 12'd10, 0, 0); step("R3");

      // R4: write and read of one entry in one cycle returns old data
      lset(1, 1, 0, 2'b11, 12'd200, 16'h1234, 0); rset(1, 0, 1, 2'b11, 12'd200, 0, 0);
      step("R4");
      lset(0, 0, 0, 2'b00, 0, 0, 0); step("R4");
      rset(1, 1, 0, 2'b11, 12'd201, 16'h4321, 0); lset(1, 0, 1, 2'b11, 12'd201, 0, 0);
      step("R4");
      rset(0, 0, 0, 2'b00, 0, 0, 0); step("R4");

      // R5: both sides write one entry together
      lset(1, 1, 0, 2'b11, 12'd300, 16'h1111, 0); rset(1, 1, 0, 2'b11, 12'd300, 16'h2222, 0);
      step("R5");
      lset(1, 1, 0, 2'b01, 12'd301, 16'h3333, 0); rset(1, 1, 0, 2'b11, 12'd301, 16'h4444, 0);
      step("R5");
      lset(1, 0, 1, 2'b11, 12'd300, 0, 0); rset(1, 0, 1, 2'b11, 12'd301, 0, 0); step("R5");

      // R7: left clears the flag raised during the fill
      idle();
      lset(1, 0, 1, 2'b11, LBOX, 0, 0); step("R7");
      idle(); step("R7");
      // R6: doorbells from each side
      rset(1, 1, 0, 2'b11, LBOX, 16'h0F0F, 0); step("R6");
      idle(); step("R6");
      lset(1, 1, 0, 2'b00, RBOX, 16'hFFFF, 0); step("R6");
      idle(); step("R6");
      // R7: right clears, then left clears with the write strobe high
      rset(1, 0, 1, 2'b11, RBOX, 0, 0); step("R7");
      idle();
      lset(1, 1, 1, 2'b01, LBOX, 16'h00C5, 0); step("R7");
      idle(); step("R7");
      rset(1, 0, 0, 2'b11, RBOX, 0, 0); step("R7");

      // R8: set and clear of the left flag in the same cycle
      lset(1, 0, 1, 2'b11, LBOX, 0, 0); rset(1, 1, 0, 2'b11, LBOX, 16'hB00B, 0); step("R8");
      idle(); step("R8");
      lset(1, 0, 1, 2'b11, LBOX, 0, 0); step("R8");
      idle();
      rset(1, 0, 1, 2'b11, RBOX, 0, 0); lset(1, 1, 0, 2'b11, RBOX, 16'hFEED, 0); step("R8");
      idle(); step("R8");
      rset(1, 0, 1, 2'b11, RBOX, 0, 0); step("R8");

      // R9: inhibited writes
      idle();
      lset(1, 1, 0, 2'b11, RBOX, 16'hDEAD, 1); step("R9");
      lset(1, 1, 0, 2'b11, 12'd400, 16'hDEAD, 1); rset(1, 1, 0, 2'b11, LBOX, 16'hBEEF, 1);
      step("R9");
      idle(); step("R9");
      lset(1, 0, 1, 2'b11, 12'd400, 0, 0); rset(1, 0, 1, 2'b11, RBOX, 0, 0); step("R9");
      lset(1, 0, 0, 2'b11, 0, 0, 0); rset(1, 0, 0, 2'b11, 0, 0, 0); step("R9");

      // R10: mailbox entries as plain storage
      lset(1, 1, 0, 2'b11, LBOX, 16'h6A6A, 0); rset(1, 1, 0, 2'b11, RBOX, 16'h9595, 0);
      step("R10");
      lset(1, 0, 0, 2'b11, 0, 0, 0); rset(1, 0, 0, 2'b11, 0, 0, 0);
      lset(1, 0, 1, 2'b11, RBOX, 0, 0); rset(1, 0, 1, 2'b11, LBOX, 0, 0); step("R10");
      idle(); step("R10");
      lset(1, 0, 1, 2'b11, LBOX, 0, 0); rset(1, 0, 1, 2'b11, RBOX, 0, 0); step("R10");
      idle(); step("R10");

      // R11: reset again in mid-run
      rset(1, 1, 0, 2'b11, LBOX, 16'h1357, 0); step("R11");
      idle();
      rst_n = 1'b0;
      step("R11");
      rst_n = 1'b1;
      step("R11");

      summary();
   end

endmodule